// File: doc/BRIEF.md
# Serial Character Transmitter with Draining Shutdown

This block turns bytes into an asynchronous serial bit stream. A single holding slot accepts one byte from a write strobe, and an internal shift register sends it out one bit per baud tick. While a frame is being shifted, the next byte can wait in the holding slot. When the frame ends, that byte moves into the shifter with no idle gap.

Three command strobes control the block. Enable lets it accept and send bytes. Disable stops it gracefully: it first finishes the frame in flight and any byte still waiting. Reset stops the line at once and throws away everything pending.

The baud tick comes from outside and sets the bit timing. Each frame sends a start bit, the data bits (least significant first), an optional parity bit in one of four flavours, and a stop bit. Two flags report the block's state. One says the holding slot can take a byte. The other says everything, including the stop bit, has been sent.

Top module: `uart_tx_drain`

## Requirements
- R1: After reset the block is disabled. `txd` is 1, `hold_empty` is 0 and `tx_empty` is 1. A write strobe while disabled is ignored and sends nothing.
- R2: An enable command sets `hold_empty` to 1 in the next cycle. The line stays at 1 until a byte is written. The start bit then appears on the first baud tick after the write.
- R3: A frame is a start bit (0), then DATA_W data bits from bit 0 upward, then the parity bit when it is selected, then a stop bit (1). Each bit lasts exactly one baud tick interval.
- R4: `par_mode` is sampled when a byte enters the shifter. The encodings are: 3'b000 even parity (the data plus the parity bit hold an even number of ones), 3'b001 odd parity, 3'b010 a fixed 0, 3'b011 a fixed 1. Any value with bit 2 set sends no parity bit, which gives a 10-bit frame.
- R5: A disable command with nothing pending drops `hold_empty` to 0 in the next cycle. Otherwise the frame in flight and any waiting byte are both sent first, and then the block disables. From the disable command on, no new writes are accepted.
- R6: A reset command forces `txd` to 1, `tx_empty` to 1 and `hold_empty` to 0 in the next cycle. It discards both the frame in flight and any waiting byte, and it leaves the block disabled. When commands coincide, reset wins over disable, and disable wins over enable.
- R7: When a frame's stop bit ends and a byte is waiting, that byte's start bit follows on the same tick, with no idle bit in between.
- R8: `hold_empty` is 1 only when the block is enabled, not draining, and the holding slot is free. An accepted write clears it in the next cycle. `tx_empty` is 1 only when both registers are empty, and it rises on the tick that ends the last stop bit. Whenever `tx_empty` is 1, `txd` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| wr_en | input | 1 | Write strobe for the holding slot |
| wr_data | input | DATA_W | Byte to send |
| cmd_enable | input | 1 | Enable command |
| cmd_disable | input | 1 | Draining disable command |
| cmd_reset | input | 1 | Aborting reset command |
| par_mode | input | 3 | Parity selection |
| txd | output | 1 | Serial line |
| hold_empty | output | 1 | Holding slot can accept a byte |
| tx_empty | output | 1 | Nothing pending and the line is idle |

## Verification
The bench builds the block with DATA_W at 8 and drives a baud tick every fourth clock. This exposes 11-bit frames (all four parity flavours, each over hand-computed bytes) as well as 10-bit frames. It records the line once per tick, so frames can be decoded bit by bit and the gap between them can be measured exactly. With the short tick interval, reset can be issued partway through a frame while a byte is waiting. It also lets a disable arrive with two frames queued, and commands can be made to coincide.

// File: rtl/uart_tx_drain.sv
module uart_tx_drain #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              cmd_enable,
  input  logic              cmd_disable,
  input  logic              cmd_reset,
  input  logic [2:0]        par_mode,
  output logic              txd,
  output logic              hold_empty,
  output logic              tx_empty
);
  localparam int SH_W  = DATA_W + 2;
  localparam int CNT_W = $clog2(DATA_W + 3);
  localparam logic [CNT_W-1:0] REM_PAR   = CNT_W'(DATA_W + 2);
  localparam logic [CNT_W-1:0] REM_NOPAR = CNT_W'(DATA_W + 1);

  logic              en_q, drain_q, hv_q, busy_q, txd_q;
  logic [DATA_W-1:0] hold_q;
  logic [SH_W-1:0]   sh_q;
  logic [CNT_W-1:0]  rem_q;
  logic              par_bit;

  wire par_on   = !par_mode[2];
  wire wr_ok    = wr_en && hold_empty && !cmd_disable && !cmd_reset;
  wire load_now = baud_tick && hv_q && (!busy_q || rem_q == '0);

  always_comb begin
    case (par_mode[1:0])
      2'b00:   par_bit = ^hold_q;
      2'b01:   par_bit = ~^hold_q;
      2'b10:   par_bit = 1'b0;
      default: par_bit = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      drain_q <= 1'b0;
      hv_q    <= 1'b0;
      busy_q  <= 1'b0;
      txd_q   <= 1'b1;
      hold_q  <= '0;
      sh_q    <= '1;
      rem_q   <= '0;
    end else if (cmd_reset) begin
      en_q    <= 1'b0;
      drain_q <= 1'b0;
      hv_q    <= 1'b0;
      busy_q  <= 1'b0;
      txd_q   <= 1'b1;
      rem_q   <= '0;
    end else begin
      if (cmd_disable) begin
        if (!busy_q && !hv_q) en_q <= 1'b0;
        else if (en_q) drain_q <= 1'b1;
      end else if (cmd_enable) begin
        en_q    <= 1'b1;
        drain_q <= 1'b0;
      end else if (drain_q && !busy_q && !hv_q) begin
        en_q    <= 1'b0;
        drain_q <= 1'b0;
      end

      if (wr_ok) begin
        hv_q   <= 1'b1;
        hold_q <= wr_data;
      end else if (load_now) begin
        hv_q <= 1'b0;
      end

      if (load_now) begin
        busy_q <= 1'b1;
        txd_q  <= 1'b0;
        sh_q   <= {1'b1, par_on ? par_bit : 1'b1, hold_q};
        rem_q  <= par_on ? REM_PAR : REM_NOPAR;
      end else if (baud_tick && busy_q) begin
        if (rem_q != '0) begin
          txd_q <= sh_q[0];
          sh_q  <= {1'b1, sh_q[SH_W-1:1]};
          rem_q <= rem_q - 1'b1;
        end else begin
          busy_q <= 1'b0;
          txd_q  <= 1'b1;
        end
      end
    end
  end

  assign txd        = txd_q;
  assign hold_empty = en_q && !drain_q && !hv_q;
  assign tx_empty   = !busy_q && !hv_q;
endmodule

// File: rtl/uart_tx_drain_chk.sv
module uart_tx_drain_chk (
  input logic clk,
  input logic rst_n,
  input logic baud_tick,
  input logic wr_en,
  input logic cmd_enable,
  input logic cmd_disable,
  input logic cmd_reset,
  input logic txd,
  input logic hold_empty,
  input logic tx_empty
);
  assert_idle_line_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> txd);

  assert_reset_aborts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reset |=> (txd && tx_empty && !hold_empty));

  assert_idle_disable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_disable && !cmd_reset && tx_empty) |=> !hold_empty);

  assert_start_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(txd) |-> $past(baud_tick));

  assert_empty_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_empty) |-> ($past(baud_tick) || $past(cmd_reset)));

  assert_write_fills_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hold_empty && !cmd_disable && !cmd_reset) |=> !hold_empty);

  assert_enable_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_enable && !cmd_disable && !cmd_reset && tx_empty) |=> hold_empty);
endmodule

bind uart_tx_drain uart_tx_drain_chk chk_i (
  .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_en(wr_en),
  .cmd_enable(cmd_enable), .cmd_disable(cmd_disable), .cmd_reset(cmd_reset),
  .txd(txd), .hold_empty(hold_empty), .tx_empty(tx_empty)
);

// File: tb/uart_tx_drain_tb_top.sv
`timescale 1ns/1ps
module uart_tx_drain_tb_top;
  logic clk = 0, rst_n = 0, baud_tick = 0, wr_en = 0;
  logic cmd_enable = 0, cmd_disable = 0, cmd_reset = 0;
  logic [7:0] wr_data = '0;
  logic [2:0] par_mode = 3'b100;
  logic txd, hold_empty, tx_empty;

  uart_tx_drain #(.DATA_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_en(wr_en),
    .wr_data(wr_data), .cmd_enable(cmd_enable), .cmd_disable(cmd_disable),
    .cmd_reset(cmd_reset), .par_mode(par_mode), .txd(txd),
    .hold_empty(hold_empty), .tx_empty(tx_empty)
  );

  always #2 clk = ~clk;

  // {mode[2:0], parity bit, data}
  localparam logic [11:0] VEC [8] = '{
    {3'd0, 1'b0, 8'h00}, {3'd1, 1'b1, 8'hA5}, {3'd0, 1'b1, 8'h01},
    {3'd1, 1'b0, 8'h7F}, {3'd2, 1'b0, 8'hFF}, {3'd3, 1'b1, 8'h00},
    {3'd4, 1'b0, 8'h3C}, {3'd0, 1'b1, 8'h80}
  };

  int n_chk = 0, n_fail = 0, tcnt = 0, nb = 0;
  bit done = 0;
  logic last_tick = 0;
  logic bitlog [4096];
  logic emptylog [4096];

  always @(negedge clk) begin
    tcnt = (tcnt + 1) % 4;
    baud_tick = (tcnt == 0);
  end
  always @(posedge clk) last_tick <= baud_tick;
  always @(negedge clk) if (last_tick && nb < 4096) begin
    bitlog[nb] = txd; emptylog[nb] = tx_empty; nb++;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write(input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic cmd(input bit e, input bit d, input bit r);
    @(negedge clk); cmd_enable = e; cmd_disable = d; cmd_reset = r;
    @(negedge clk); cmd_enable = 0; cmd_disable = 0; cmd_reset = 0;
  endtask

  task automatic wait_hold();
    for (int k = 0; k < 200 && !hold_empty; k++) @(negedge clk);
  endtask

  function automatic int zeros_from(input int from);
    int z = 0;
    for (int i = from; i < nb; i++) if (!bitlog[i]) z++;
    return z;
  endfunction

  task automatic frame(input int from, input logic [7:0] d, input logic [2:0] mode,
                       input logic p, input string tag, output int start, output int nxt);
    logic [11:0] got, exp;
    int len = mode[2] ? 10 : 11;
    int i = from;
    got = '1; exp = '1;
    exp[0] = 1'b0; exp[8:1] = d;
    if (!mode[2]) exp[9] = p;
    while (i < nb && bitlog[i]) i++;
    start = i;
    if (i + len <= nb) for (int k = 0; k < len; k++) got[k] = bitlog[i + k];
    nxt = i + len;
    chk(got == exp, tag, {20'd0, got}, {20'd0, exp});
  endtask

  int s, n, m;

  initial begin
    cyc(5); rst_n = 1; cyc(2);
    chk(txd === 1'b1 && hold_empty === 1'b0 && tx_empty === 1'b1, "R1 reset state",
        {txd, hold_empty, tx_empty}, 3'b101);
    m = nb; write(8'h55); cyc(40);
    chk(zeros_from(m) == 0 && tx_empty, "R1 write while disabled ignored", zeros_from(m), 0);

    cmd(1, 0, 0);
    chk(hold_empty === 1'b1, "R2 enable opens holding slot", hold_empty, 1);
    m = nb; cyc(24);
    chk(zeros_from(m) == 0, "R2 idle until write", zeros_from(m), 0);

    for (int v = 0; v < 8; v++) begin
      par_mode = VEC[v][11:9];
      m = nb; write(VEC[v][7:0]); cyc(60);
      frame(m, VEC[v][7:0], VEC[v][11:9], VEC[v][8], $sformatf("R3 R4 frame vector %0d", v), s, n);
    end

    // tx_empty timing, 10-bit and 11-bit frames
    for (int pm = 0; pm < 2; pm++) begin
      par_mode = pm ? 3'b100 : 3'b001;
      m = nb; write(8'h96); cyc(60);
      frame(m, 8'h96, par_mode, 1'b1, "R3 frame for empty timing", s, n);
      chk(emptylog[s] == 0 && emptylog[n - 1] == 0 && emptylog[n] == 1,
          "R8 tx_empty rises at end of stop bit", {emptylog[n - 1], emptylog[n]}, 2'b01);
    end

    // back-to-back
    par_mode = 3'b100;
    m = nb; write(8'hC3); wait_hold(); write(8'h5A);
    chk(!hold_empty && !tx_empty, "R8 flags with byte waiting", {hold_empty, tx_empty}, 0);
    cyc(100);
    frame(m, 8'hC3, 3'b100, 1'b0, "R7 first frame", s, n);
    chk(bitlog[n] == 1'b0, "R7 no idle bit between frames", bitlog[n], 0);
    frame(n, 8'h5A, 3'b100, 1'b0, "R7 second frame", s, n);
    chk(tx_empty && hold_empty, "R8 flags after drain", {hold_empty, tx_empty}, 3);

    // graceful disable
    par_mode = 3'b000;
    m = nb; write(8'h12); wait_hold(); write(8'hE7);
    cmd(0, 1, 0);
    chk(!hold_empty && !tx_empty, "R5 draining blocks writes", {hold_empty, tx_empty}, 0);
    cyc(120);
    frame(m, 8'h12, 3'b000, 1'b0, "R5 drained frame one", s, n);
    chk(bitlog[n] == 1'b0, "R5 waiting byte follows", bitlog[n], 0);
    frame(n, 8'hE7, 3'b000, 1'b0, "R5 drained frame two", s, n);
    chk(tx_empty && !hold_empty, "R5 disabled after drain", {hold_empty, tx_empty}, 1);
    m = nb; write(8'h00); cyc(60);
    chk(zeros_from(m) == 0, "R5 write after disable ignored", zeros_from(m), 0);

    // idle disable
    cmd(1, 0, 0);
    chk(hold_empty, "R2 re-enable", hold_empty, 1);
    cmd(0, 1, 0);
    chk(!hold_empty, "R5 idle disable immediate", hold_empty, 0);

    // reset mid-frame with byte waiting
    cmd(1, 0, 0);
    write(8'h0F); wait_hold(); write(8'hF0); cyc(10);
    chk(!tx_empty, "R6 frame in flight before reset", tx_empty, 0);
    cmd(0, 0, 1);
    chk(txd && tx_empty && !hold_empty, "R6 reset aborts", {txd, hold_empty, tx_empty}, 3'b101);
    cmd(1, 0, 0);
    m = nb; cyc(100);
    chk(zeros_from(m) == 0, "R6 discarded bytes not sent", zeros_from(m), 0);

    // priorities
    cmd(1, 0, 1);
    chk(!hold_empty, "R6 reset beats enable", hold_empty, 0);
    cmd(1, 0, 0);
    cmd(1, 1, 0);
    chk(!hold_empty, "R6 disable beats enable", hold_empty, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule